// File: doc/BRIEF.md
# SPI Status Register Protection Controller

This block is the slave-side command logic of a serial flash device that owns the status register and the write-enable state. It watches an SPI slave interface in clock mode 0 or mode 3. Chip select, serial clock, data in and the write-protect pin are resynchronised into the system clock domain. Each transfer is collected as one opcode byte, optionally followed by one data byte, both most significant bit first. The block acts on the transfer only when chip select rises.

Four instructions are recognised: set the write-enable latch, clear it, arm a status write, and write the status register. A status write goes through only if the instruction just before it armed it. A lock bit, together with the write-protect pin, can freeze the protection bits. An external programming engine drives the busy input and can set the auto-increment flag. The block reports the busy input, the latch, the flag and the protection bits in one status word. It never drives the data-out line.

Top module: `spi_sr_guard`

## Requirements
- R1: A complete 8-bit transfer of opcode 0x06 sets the write-enable latch. The latch does not change while chip select is still low, and changes only after chip select rises.
- R2: A complete 8-bit transfer of opcode 0x04 clears the write-enable latch and the auto-increment flag. The busy bit keeps following the busy input.
- R3: Bits are taken most significant bit first on rising serial-clock edges. The bit-reversed pattern 0x60 therefore has no effect.
- R4: After opcode 0x50, a 16-bit transfer of opcode 0x01 plus a data byte loads the lock bit from data bit 7 and the three protect bits from data bits 4..2. It also clears the write-enable latch. Data bits 6, 5, 1 and 0 are not stored.
- R5: A status write that directly follows opcode 0x06 is accepted in the same way as one that follows 0x50.
- R6: A status write whose preceding instruction was anything other than 0x06 or 0x50 changes nothing. This includes a second status write in a row, or a write after 0x04.
- R7: When the lock bit is 1 and the protect pin is low at the rising edge of chip select, a status write changes nothing at all, including the write-enable latch.
- R8: When the lock bit is 0 and the protect pin is low, a status write may set the lock bit and change the protect bits in the same instruction.
- R9: While the protect pin is high, a status write can clear the lock bit as well as set it.
- R10: The protect pin is judged only at the chip-select rise that ends the status write, not while the bytes are shifted in.
- R11: A transfer whose bit count is not exactly what its opcode needs (8 for 0x06, 0x04 and 0x50; 16 for 0x01) is discarded and disarms a following status write.
- R12: The status word holds busy in bit 0, the write-enable latch in bit 1, the protect bits in bits 4..2, a constant 0 in bit 5, the auto-increment flag in bit 6 and the lock bit in bit 7. The separate flag outputs match these bits.
- R13: The data-out enable stays low at all times. An asserted auto-increment set input raises the flag.
- R14: Transfers in clock mode 0 (clock idle low) and clock mode 3 (clock idle high) are decoded alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI data into the block |
| miso | output | 1 | SPI data out (never driven with data) |
| miso_oe | output | 1 | Output enable for miso, held low |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Busy flag from the programming engine |
| autoinc_set | input | 1 | Pulse from the programming engine that sets the auto-increment flag |
| wel | output | 1 | Write-enable latch |
| aai | output | 1 | Auto-increment flag |
| bp | output | 3 | Block-protect bits |
| bpl | output | 1 | Protect-lock bit |
| status | output | 8 | Status read-back word |

## Verification
The hardest case to reach is the protect pin changing inside a status write. The lock decision must use only the level present at the closing chip-select edge. The bench holds chip select low after the sixteenth bit and flips the pin. It waits long enough for the synchroniser to settle, then raises chip select. It does this in both directions: once where the late release lets the write through, and once where the late assertion blocks it. Partial transfers also need special care. The bench sends truncated and overlong frames right after an arming opcode, then follows them with a correct status write, which must be refused.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam int OP_BITS   = 8;
    localparam int DATA_BITS = 8;
    localparam int FRAME_MAX = OP_BITS + DATA_BITS;
    localparam int CNT_W     = $clog2(FRAME_MAX + 2);
    localparam int BP_W      = 3;

    localparam logic [OP_BITS-1:0] OP_SET_WE  = 8'h06;
    localparam logic [OP_BITS-1:0] OP_CLR_WE  = 8'h04;
    localparam logic [OP_BITS-1:0] OP_ARM_SR  = 8'h50;
    localparam logic [OP_BITS-1:0] OP_LOAD_SR = 8'h01;

    typedef struct packed {
        logic            lock;
        logic            autoinc;
        logic            spare;
        logic [BP_W-1:0] prot;
        logic            we_latch;
        logic            busy;
    } sr_word_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_SET_WE,
        CMD_CLR_WE,
        CMD_ARM_SR,
        CMD_LOAD_SR
    } sr_cmd_e;

    function automatic sr_cmd_e decode_frame(
        input logic [FRAME_MAX-1:0] bits,
        input logic [CNT_W-1:0]     count
    );
        sr_cmd_e cmd;
        cmd = CMD_NONE;
        if (count == CNT_W'(OP_BITS)) begin
            case (bits[OP_BITS-1:0])
                OP_SET_WE: cmd = CMD_SET_WE;
                OP_CLR_WE: cmd = CMD_CLR_WE;
                OP_ARM_SR: cmd = CMD_ARM_SR;
                default:   cmd = CMD_NONE;
            endcase
        end else if (count == CNT_W'(FRAME_MAX)) begin
            if (bits[FRAME_MAX-1:DATA_BITS] == OP_LOAD_SR)
                cmd = CMD_LOAD_SR;
        end
        return cmd;
    endfunction

    function automatic logic load_permitted(input logic pin_n, input logic lock_now);
        return pin_n | ~lock_now;
    endfunction

endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
    parameter int             STAGES  = 2,
    parameter int             WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_sr_shift.sv
module spi_sr_shift
    import spi_sr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_s,
    input  logic                 sck_s,
    input  logic                 mosi_s,
    output logic                 frame_vld,
    output logic [CNT_W-1:0]     frame_cnt,
    output logic [FRAME_MAX-1:0] frame_bits
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_MAX + 1);

    logic cs_q, sck_q;
    logic sck_rise, cs_fall;

    assign sck_rise  = sck_s & ~sck_q & ~cs_s;
    assign cs_fall   = ~cs_s & cs_q;
    assign frame_vld = cs_s & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q       <= 1'b1;
            sck_q      <= 1'b0;
            frame_cnt  <= '0;
            frame_bits <= '0;
        end else begin
            cs_q  <= cs_s;
            sck_q <= sck_s;
            if (cs_fall) begin
                frame_cnt  <= '0;
                frame_bits <= '0;
            end else if (sck_rise) begin
                frame_bits <= {frame_bits[FRAME_MAX-2:0], mosi_s};
                if (frame_cnt != CNT_SAT)
                    frame_cnt <= frame_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_sr_state.sv
module spi_sr_state
    import spi_sr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_vld,
    input  sr_cmd_e              cmd,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 wp_s,
    input  logic                 busy,
    input  logic                 autoinc_set,
    output sr_word_t             word,
    output logic                 armed
);

    sr_word_t regs_q;
    sr_word_t wr_img;

    always_comb begin
        wr_img          = sr_word_t'(data);
        wr_img.busy     = 1'b0;
        wr_img.we_latch = 1'b0;
        wr_img.spare    = 1'b0;
        wr_img.autoinc  = regs_q.autoinc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
            armed  <= 1'b0;
        end else begin
            if (autoinc_set)
                regs_q.autoinc <= 1'b1;
            if (frame_vld) begin
                armed <= 1'b0;
                unique case (cmd)
                    CMD_SET_WE: begin
                        regs_q.we_latch <= 1'b1;
                        armed           <= 1'b1;
                    end
                    CMD_CLR_WE: begin
                        regs_q.we_latch <= 1'b0;
                        regs_q.autoinc  <= 1'b0;
                    end
                    CMD_ARM_SR: armed <= 1'b1;
                    CMD_LOAD_SR: begin
                        if (armed && load_permitted(wp_s, regs_q.lock)) begin
                            regs_q.lock     <= wr_img.lock;
                            regs_q.prot     <= wr_img.prot;
                            regs_q.we_latch <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        word       = regs_q;
        word.busy  = busy;
        word.spare = 1'b0;
    end

endmodule

// File: rtl/spi_sr_guard.sv
module spi_sr_guard
    import spi_sr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            mosi,
    output logic            miso,
    output logic            miso_oe,
    input  logic            wp_n,
    input  logic            busy,
    input  logic            autoinc_set,
    output logic            wel,
    output logic            aai,
    output logic [BP_W-1:0] bp,
    output logic            bpl,
    output logic [7:0]      status
);

    logic [3:0]           pins_s;
    logic                 frame_vld;
    logic [CNT_W-1:0]     frame_cnt;
    logic [FRAME_MAX-1:0] frame_bits;
    sr_cmd_e              frame_cmd;
    sr_word_t             word;
    logic                 armed;
    logic                 wp_s;

    spi_sr_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (4),
        .RST_VAL (4'b1001)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cs_n, sck, mosi, wp_n}),
        .dout (pins_s)
    );

    assign wp_s = pins_s[0];

    spi_sr_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .cs_s       (pins_s[3]),
        .sck_s      (pins_s[2]),
        .mosi_s     (pins_s[1]),
        .frame_vld  (frame_vld),
        .frame_cnt  (frame_cnt),
        .frame_bits (frame_bits)
    );

    assign frame_cmd = decode_frame(frame_bits, frame_cnt);

    spi_sr_state u_state (
        .clk         (clk),
        .rst         (rst),
        .frame_vld   (frame_vld),
        .cmd         (frame_cmd),
        .data        (frame_bits[DATA_BITS-1:0]),
        .wp_s        (wp_s),
        .busy        (busy),
        .autoinc_set (autoinc_set),
        .word        (word),
        .armed       (armed)
    );

    assign miso    = 1'b0;
    assign miso_oe = 1'b0;
    assign wel     = word.we_latch;
    assign aai     = word.autoinc;
    assign bp      = word.prot;
    assign bpl     = word.lock;
    assign status  = word;

endmodule

// File: rtl/spi_sr_guard_chk.sv
module spi_sr_guard_chk
    import spi_sr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       frame_vld,
    input sr_cmd_e    frame_cmd,
    input logic       armed,
    input logic       wp_s,
    input logic [7:0] status
);

    // R1
    wel_only_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> $stable(status[1]));

    // R2
    clear_we_drops_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && frame_cmd == CMD_CLR_WE) |=> (!status[1] && !status[6]));

    // R6
    unarmed_load_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && frame_cmd == CMD_LOAD_SR && !armed)
        |=> ($stable(status[4:1]) && $stable(status[7])));

    // R7
    lock_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && !wp_s && status[7])
        |=> (status[7] && $stable(status[4:2])));

    // R11
    prot_only_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> ($stable(status[4:2]) && $stable(status[7])));

endmodule

bind spi_sr_guard spi_sr_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .frame_cmd (frame_cmd),
    .armed     (armed),
    .wp_s      (wp_s),
    .status    (status)
);

// File: tb/sim_spi_sr_guard.sv
module sim_spi_sr_guard;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic       wp_n = 1'b1, busy = 1'b0, autoinc_set = 1'b0;
    logic       miso, miso_oe, wel, aai, bpl;
    logic [2:0] bp;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_sr_guard u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .wp_n(wp_n), .busy(busy),
        .autoinc_set(autoinc_set), .wel(wel), .aai(aai), .bp(bp),
        .bpl(bpl), .status(status)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic begin_frame(input logic [15:0] val, input int nbits, input bit mode3);
        sck = mode3;
        idle(10);
        cs_n = 1'b0;
        idle(10);
        for (int i = nbits - 1; i >= 0; i--) begin
            if (mode3) sck = 1'b0;
            mosi = val[i];
            idle(10);
            sck = 1'b1;
            idle(10);
            if (!mode3) sck = 1'b0;
        end
        idle(10);
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        idle(12);
    endtask

    task automatic frame(input logic [15:0] val, input int nbits, input bit mode3);
        begin_frame(val, nbits, mode3);
        end_frame();
    endtask

    task automatic chk_ports(input string req);
        chk(req, {bpl, aai, 1'b0, bp, wel, busy}, status);
        chk(req, {7'd0, miso_oe}, 8'h00);
    endtask

    task automatic t_reset();
        chk("R12 reset", status, 8'h00);
        chk_ports("R13 reset");
    endtask

    task automatic t_set_we();
        begin_frame(16'h0006, 8, 1'b0);
        chk("R1 before cs rise", status, 8'h00);
        end_frame();
        chk("R1 after cs rise", status, 8'h02);
    endtask

    task automatic t_msb_first();
        frame(16'h0004, 8, 1'b0);
        frame(16'h0060, 8, 1'b0);
        chk("R3 reversed opcode", status, 8'h00);
    endtask

    task automatic t_clear_we();
        @(negedge clk) autoinc_set = 1'b1;
        @(negedge clk) autoinc_set = 1'b0;
        busy = 1'b1;
        frame(16'h0006, 8, 1'b0);
        chk("R13 autoinc set", status, 8'h43);
        chk_ports("R12 fields");
        frame(16'h0004, 8, 1'b0);
        chk("R2 clear we", status, 8'h01);
        busy = 1'b0;
        idle(2);
        chk("R2 busy follows", status, 8'h00);
    endtask

    task automatic t_arm_load();
        frame(16'h0050, 8, 1'b0);
        frame(16'h01BF, 16, 1'b0);
        chk("R4 load after arm", status, 8'h9C);
        chk_ports("R12 after load");
    endtask

    task automatic t_we_load_mode3();
        frame(16'h0006, 8, 1'b1);
        chk("R14 mode3 set we", status, 8'h9E);
        frame(16'h0108, 16, 1'b1);
        chk("R5 R9 load after set we", status, 8'h08);
    endtask

    task automatic t_unarmed();
        frame(16'h0184, 16, 1'b0);
        chk("R6 no arm", status, 8'h08);
        frame(16'h0050, 8, 1'b0);
        frame(16'h0004, 8, 1'b0);
        frame(16'h0184, 16, 1'b0);
        chk("R6 intervening op", status, 8'h08);
        frame(16'h0050, 8, 1'b0);
        frame(16'h010C, 16, 1'b0);
        frame(16'h0100, 16, 1'b0);
        chk("R6 second load", status, 8'h0C);
    endtask

    task automatic t_lock();
        wp_n = 1'b0;
        frame(16'h0050, 8, 1'b0);
        frame(16'h0194, 16, 1'b0);
        chk("R8 set lock with pin low", status, 8'h94);
        frame(16'h0050, 8, 1'b0);
        frame(16'h0100, 16, 1'b0);
        chk("R7 locked", status, 8'h94);
        frame(16'h0006, 8, 1'b0);
        frame(16'h0100, 16, 1'b0);
        chk("R7 locked keeps we", status, 8'h96);
    endtask

    task automatic t_pin_timing();
        frame(16'h0050, 8, 1'b0);
        begin_frame(16'h0100, 16, 1'b0);
        wp_n = 1'b1;
        idle(10);
        end_frame();
        chk("R10 pin released late", status, 8'h00);
        frame(16'h0050, 8, 1'b0);
        frame(16'h0180, 16, 1'b0);
        chk("R9 set lock pin high", status, 8'h80);
        frame(16'h0050, 8, 1'b0);
        begin_frame(16'h0100, 16, 1'b0);
        wp_n = 1'b0;
        idle(10);
        end_frame();
        chk("R10 pin asserted late", status, 8'h80);
        wp_n = 1'b1;
        frame(16'h0050, 8, 1'b0);
        frame(16'h0100, 16, 1'b0);
        chk("R9 clear lock", status, 8'h00);
    endtask

    task automatic t_partial();
        frame(16'h0050, 8, 1'b0);
        frame(16'h00CE, 15, 1'b0);
        chk("R11 short load", status, 8'h00);
        frame(16'h019C, 16, 1'b0);
        chk("R11 disarmed", status, 8'h00);
        frame(16'h0003, 7, 1'b0);
        chk("R11 seven bits", status, 8'h00);
        frame(16'h000C, 9, 1'b1);
        chk("R11 nine bits", status, 8'h00);
        frame(16'h0050, 8, 1'b0);
        frame(16'h0001, 8, 1'b0);
        frame(16'h019C, 16, 1'b0);
        chk("R11 load without data", status, 8'h00);
        chk_ports("R13 end");
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        idle(5);
        t_reset();
        t_set_we();
        t_msb_first();
        t_clear_we();
        t_arm_load();
        t_we_load_mode3();
        t_unarmed();
        t_lock();
        t_pin_timing();
        t_partial();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule